// File: doc/BRIEF.md
# Eight-Channel Sampling Converter Host Interface

This block is the digital side of an eight-channel sampling converter that sits on a 10-bit bidirectional host bus. The bus has three active-low strobes: select, read and write. A host write does two things at once. It loads a 10-bit configuration word, and it starts a conversion on the channel named in that word. The block first tracks the input for a fixed number of converter clocks and then holds it. After a fixed conversion time it captures the chosen channel's 10-bit sample, which the analog front end supplies on a port.

While a conversion runs, the busy output is low. When the conversion completes, busy returns high and an interrupt output goes low. The interrupt stays low until the host starts reading. A mode bit in the configuration word chooses how the host fetches the result. In one mode a single read returns all 10 bits. In the other mode two reads split the result into an upper 8-bit part and a lower 2-bit part.

All three strobes are brought into the converter clock domain through two-flop synchronisers, and every bus event is detected on the synchronised levels. The bus output enable is the only path that works directly from the raw pins.

Top module: `adc_bus_ctrl`

## Requirements
- R1: After reset, busy_n and irq_n are both high. The configuration word is all zeros, so the interface is in single-read mode. The result register is zero, so a read returns 0.
- R2: A write is accepted when a rising edge on wr_n occurs while cs_n is low and rd_n is high, and no conversion is running. An accepted write stores data_io as the configuration word and drives busy_n low for exactly TRACK_CYC + CONV_CYC clock cycles (default 4 + 10 = 14).
- R3: Configuration bits [2:0] select the channel. At completion the result becomes sample_i[ch*10 +: 10] of that channel.
- R4: While cs_n is high, data_io is not driven, and edges on wr_n and rd_n have no effect: no conversion starts and no read is counted.
- R5: irq_n goes low in the same cycle that busy_n returns high. It stays low until the falling edge of a read is taken, or until a new write is accepted. busy_n and irq_n are never low together.
- R6: With configuration bit 6 at 0, every read returns the full 10-bit result, and repeated reads return the same value.
- R7: With configuration bit 6 at 1, reads alternate between two forms. The first form is {2'b00, result[9:2]}. The second form is {result[1:0], 8'b0}. The rising edge of each read advances the alternation.
- R8: Every accepted write returns the two-read alternation to its first (upper-part) form.
- R9: A write that arrives while busy_n is low is ignored. The configuration word and the channel are unchanged, and the busy interval is not extended.
- R10: data_io is driven only while cs_n and rd_n are low and wr_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe; rising edge loads the configuration word |
| data_io | inout | 10 | Bidirectional host data bus |
| sample_i | input | 80 | Per-channel 10-bit samples, channel i at bits [i*10 +: 10] |
| busy_n | output | 1 | Low while a conversion is in progress |
| irq_n | output | 1 | Low from completion until the first read or the next accepted write |

## Verification
The conversion path is tried across all eight channel codes, each with a distinct sample value, so that a wrong select bit or wrong slice offset gives a different result. Single-read mode is checked against two-read mode on the same kind of sample: repeated reads must stay identical in one mode and alternate between the two formats in the other, which separates bit-6 decoding from pointer handling. A write issued partway through a conversion, a write issued with select high, and a rewrite after a half-finished two-read sequence separate the guard on new writes, the select gating, and the pointer reset on write. Busy is measured in cycles, so any change to the track or conversion count shows up directly.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_TRACK = 2'd1,
        SEQ_CONV  = 2'd2
    } seq_state_e;

    // strobe lane positions inside the synchroniser vector
    localparam int LANE_CS = 0;
    localparam int LANE_RD = 1;
    localparam int LANE_WR = 2;
    localparam int LANES   = 3;

endpackage

// File: rtl/adc_strobe_sync.sv
module adc_strobe_sync #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] lvl_o,
    output logic [N-1:0] rise_o,
    output logic [N-1:0] fall_o
);

    typedef struct packed {
        logic meta;
        logic sync;
        logic prev;
    } lane_t;

    for (genvar g = 0; g < N; g++) begin : g_lane
        lane_t lane_d, lane_q;

        always_comb begin
            lane_d      = lane_q;
            lane_d.meta = raw_i[g];
            lane_d.sync = lane_q.meta;
            lane_d.prev = lane_q.sync;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                lane_q <= '{meta: 1'b1, sync: 1'b1, prev: 1'b1};
            end else begin
                lane_q <= lane_d;
            end
        end

        assign lvl_o[g]  = lane_q.sync;
        assign rise_o[g] = lane_q.sync & ~lane_q.prev;
        assign fall_o[g] = ~lane_q.sync & lane_q.prev;
    end

endmodule

// File: rtl/adc_conv_seq.sv
module adc_conv_seq
    import adc_bus_pkg::*;
#(
    parameter int TRACK_CYC = 4,
    parameter int CONV_CYC  = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int MAX_CYC = (TRACK_CYC > CONV_CYC) ? TRACK_CYC : CONV_CYC;
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    typedef struct packed {
        seq_state_e       st;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;
    logic done_d;

    always_comb begin
        seq_d  = seq_q;
        done_d = 1'b0;
        unique case (seq_q.st)
            SEQ_IDLE: begin
                if (start_i) begin
                    seq_d.st  = SEQ_TRACK;
                    seq_d.cnt = '0;
                end
            end
            SEQ_TRACK: begin
                if (seq_q.cnt == CNT_W'(TRACK_CYC - 1)) begin
                    seq_d.st  = SEQ_CONV;
                    seq_d.cnt = '0;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            SEQ_CONV: begin
                if (seq_q.cnt == CNT_W'(CONV_CYC - 1)) begin
                    seq_d.st  = SEQ_IDLE;
                    seq_d.cnt = '0;
                    done_d    = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: begin
                seq_d.st  = SEQ_IDLE;
                seq_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: SEQ_IDLE, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign busy_o = (seq_q.st != SEQ_IDLE);
    assign done_o = done_d;

endmodule

// File: rtl/adc_readout.sv
module adc_readout #(
    parameter int DW   = 10,
    parameter int HI_W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [DW-1:0] sample_i,
    input  logic          split_i,
    input  logic          rd_rise_i,
    input  logic          clr_ptr_i,
    output logic [DW-1:0] word_o
);

    localparam int LO_W = DW - HI_W;

    typedef struct packed {
        logic [DW-1:0] result;
        logic          ptr;
    } rdo_t;

    rdo_t rdo_d, rdo_q;

    always_comb begin
        rdo_d = rdo_q;
        if (load_i) begin
            rdo_d.result = sample_i;
        end
        if (clr_ptr_i) begin
            rdo_d.ptr = 1'b0;
        end else if (rd_rise_i && split_i) begin
            rdo_d.ptr = ~rdo_q.ptr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdo_q <= '0;
        end else begin
            rdo_q <= rdo_d;
        end
    end

    always_comb begin
        if (!split_i) begin
            word_o = rdo_q.result;
        end else if (!rdo_q.ptr) begin
            word_o = {{LO_W{1'b0}}, rdo_q.result[DW-1 -: HI_W]};
        end else begin
            word_o = {rdo_q.result[LO_W-1:0], {HI_W{1'b0}}};
        end
    end

endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
    import adc_bus_pkg::*;
#(
    parameter int NCH       = 8,
    parameter int DW        = 10,
    parameter int HI_W      = 8,
    parameter int TRACK_CYC = 4,
    parameter int CONV_CYC  = 10,
    parameter int SPLIT_BIT = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic              wr_n,
    inout  wire  [DW-1:0]     data_io,
    input  logic [NCH*DW-1:0] sample_i,
    output logic              busy_n,
    output logic              irq_n
);

    localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic [DW-1:0] ctrl;
        logic          irq;
    } top_t;

    top_t top_d, top_q;

    logic [LANES-1:0] s_lvl, s_rise, s_fall;
    logic             busy, done;
    logic             wr_evt, accept, rd_rise_evt, rd_fall_evt;
    logic [CH_W-1:0]  ch_sel;
    logic [DW-1:0]    sel_sample, rd_word, ctrl_cur;
    logic             bus_oe;

    adc_strobe_sync #(.N(LANES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({wr_n, rd_n, cs_n}),
        .lvl_o  (s_lvl),
        .rise_o (s_rise),
        .fall_o (s_fall)
    );

    assign wr_evt      = s_rise[LANE_WR] & ~s_lvl[LANE_CS] & s_lvl[LANE_RD];
    assign accept      = wr_evt & ~busy;
    assign rd_rise_evt = s_rise[LANE_RD] & ~s_lvl[LANE_CS] & s_lvl[LANE_WR];
    assign rd_fall_evt = s_fall[LANE_RD] & ~s_lvl[LANE_CS] & s_lvl[LANE_WR];

    adc_conv_seq #(
        .TRACK_CYC (TRACK_CYC),
        .CONV_CYC  (CONV_CYC)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (accept),
        .busy_o  (busy),
        .done_o  (done)
    );

    assign ch_sel     = top_q.ctrl[CH_W-1:0];
    assign sel_sample = sample_i[ch_sel*DW +: DW];

    adc_readout #(
        .DW   (DW),
        .HI_W (HI_W)
    ) u_rdo (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (done),
        .sample_i  (sel_sample),
        .split_i   (top_q.ctrl[SPLIT_BIT]),
        .rd_rise_i (rd_rise_evt),
        .clr_ptr_i (accept),
        .word_o    (rd_word)
    );

    always_comb begin
        top_d = top_q;
        if (accept) begin
            top_d.ctrl = data_io;
        end
        if (done) begin
            top_d.irq = 1'b1;
        end else if (rd_fall_evt || accept) begin
            top_d.irq = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign ctrl_cur = top_q.ctrl;
    assign bus_oe   = ~cs_n & ~rd_n & wr_n;
    assign data_io  = bus_oe ? rd_word : {DW{1'bz}};
    assign busy_n   = ~busy;
    assign irq_n    = ~top_q.irq;

endmodule

// File: rtl/adc_bus_ctrl_chk.sv
module adc_bus_ctrl_chk #(
    parameter int DW      = 10,
    parameter int RUN_LEN = 14
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cs_n,
    input logic          rd_n,
    input logic          wr_n,
    input logic          bus_oe,
    input logic          busy_n,
    input logic          irq_n,
    input logic [DW-1:0] ctrl_q
);

    localparam int RW = $clog2(RUN_LEN + 2);

    logic [RW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (!busy_n) begin
            run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    // R2
    busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_n) |-> (run_q == RW'(RUN_LEN)));

    // R2
    busy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q <= RW'(RUN_LEN));

    // R9
    ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_n && $past(!busy_n)) |-> $stable(ctrl_q));

    // R5
    irq_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq_n) |-> $rose(busy_n));

    // R5
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!busy_n && !irq_n));

    // R10
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (!cs_n && !rd_n && wr_n));

    // R4
    cs_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !bus_oe);

endmodule

bind adc_bus_ctrl adc_bus_ctrl_chk #(
    .DW      (DW),
    .RUN_LEN (TRACK_CYC + CONV_CYC)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .bus_oe (bus_oe),
    .busy_n (busy_n),
    .irq_n  (irq_n),
    .ctrl_q (ctrl_cur)
);

// File: tb/adc_bus_ctrl_bench.sv
module adc_bus_ctrl_bench;

    localparam int NCH = 8;
    localparam int DW  = 10;
    localparam int RUN = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cs_n = 1'b1;
    logic              rd_n = 1'b1;
    logic              wr_n = 1'b1;
    logic              host_drv = 1'b0;
    logic [DW-1:0]     host_val = '0;
    logic [NCH*DW-1:0] samples;
    wire  [DW-1:0]     bus;
    logic              busy_n, irq_n;

    int tests = 0;
    int fails = 0;
    int run_cnt = 0;
    int last_run = 0;
    bit busy_seen = 0;

    assign bus = host_drv ? host_val : {DW{1'bz}};

    always #4 clk = ~clk;

    adc_bus_ctrl u_adc_bus_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_n     (cs_n),
        .rd_n     (rd_n),
        .wr_n     (wr_n),
        .data_io  (bus),
        .sample_i (samples),
        .busy_n   (busy_n),
        .irq_n    (irq_n)
    );

    function automatic logic [DW-1:0] sval(int i);
        return DW'(10'h2B7 + i * 91);
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            if (!busy_n) begin
                run_cnt  <= run_cnt + 1;
                busy_seen <= 1'b1;
            end else if (run_cnt != 0) begin
                last_run <= run_cnt;
                run_cnt  <= 0;
            end
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic host_write(logic [DW-1:0] v, bit sel);
        @(negedge clk);
        host_val = v;
        host_drv = 1'b1;
        cs_n     = ~sel;
        cycles(2);
        wr_n = 1'b0;
        cycles(3);
        wr_n = 1'b1;
        cycles(4);
        cs_n     = 1'b1;
        host_drv = 1'b0;
    endtask

    task automatic host_read(output logic [DW-1:0] v, input bit sel);
        @(negedge clk);
        cs_n = ~sel;
        cycles(1);
        rd_n = 1'b0;
        cycles(3);
        v = bus;
        rd_n = 1'b1;
        cycles(4);
        cs_n = 1'b1;
        cycles(1);
    endtask

    task automatic wait_done();
        int k = 0;
        while (busy_n && k < 10) begin cycles(1); k++; end
        k = 0;
        while (!busy_n && k < 60) begin cycles(1); k++; end
        cycles(2);
    endtask

    task automatic t_reset();
        logic [DW-1:0] v;
        check("R1 busy_n", busy_n, 1);
        check("R1 irq_n", irq_n, 1);
        host_read(v, 1);
        check("R1 zero result", v, 0);
    endtask

    task automatic t_cs_gate();
        logic [DW-1:0] v;
        busy_seen = 0;
        host_write(10'h003, 0);
        cycles(20);
        check("R4 write ignored with cs high", busy_seen, 0);
        host_read(v, 0);
        host_read(v, 1);
        check("R4 config unchanged", v, 0);
    endtask

    task automatic t_single();
        logic [DW-1:0] v;
        host_write(10'h003, 1);
        wait_done();
        check("R2 busy length", last_run, RUN);
        check("R5 irq low after done", irq_n, 0);
        check("R5 busy high at done", busy_n, 1);
        host_read(v, 0);
        check("R4 read ignored with cs high", irq_n, 0);
        host_read(v, 1);
        check("R3 R6 channel 3 result", v, sval(3));
        check("R5 irq cleared by read", irq_n, 1);
        host_read(v, 1);
        check("R6 repeat read", v, sval(3));
    endtask

    task automatic t_channels();
        logic [DW-1:0] v;
        for (int c = 0; c < NCH; c++) begin
            host_write(DW'(c), 1);
            wait_done();
            host_read(v, 1);
            check("R3 channel select", v, sval(c));
        end
    endtask

    task automatic t_split();
        logic [DW-1:0] v, s;
        s = sval(5);
        host_write(10'h045, 1);
        wait_done();
        host_read(v, 1);
        check("R7 upper part", v, {2'b00, s[9:2]});
        host_read(v, 1);
        check("R7 lower part", v, {s[1:0], 8'b0});
        host_read(v, 1);
        check("R7 wraps to upper", v, {2'b00, s[9:2]});
    endtask

    task automatic t_ptr_reset();
        logic [DW-1:0] v, s;
        s = sval(2);
        host_write(10'h042, 1);
        wait_done();
        host_read(v, 1);
        host_write(10'h042, 1);
        check("R5 irq cleared by write", irq_n, 1);
        wait_done();
        host_read(v, 1);
        check("R8 pointer reset by write", v, {2'b00, s[9:2]});
    endtask

    task automatic t_busy_ignore();
        logic [DW-1:0] v;
        host_write(10'h001, 1);
        check("R9 busy after first write", busy_n, 0);
        host_write(10'h046, 1);
        wait_done();
        check("R9 busy not extended", last_run, RUN);
        host_read(v, 1);
        check("R9 channel and mode kept", v, sval(1));
    endtask

    initial begin
        for (int i = 0; i < NCH; i++) samples[i*DW +: DW] = sval(i);
        cycles(3);
        rst_n = 1'b1;
        cycles(2);
        t_reset();
        t_cs_gate();
        t_single();
        t_channels();
        t_split();
        t_ptr_reset();
        t_busy_ignore();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule